// File: doc/BRIEF.md
# Biphase-mark audio frame serializer

This block turns a stream of stereo 24-bit two's-complement sample pairs into a single self-clocking serial line for a consumer digital audio link. Every accepted pair becomes one frame of two 32-slot sub-frames, channel A first and channel B second. Each sub-frame opens with a sync preamble, which carries either the block-start marker, the channel-A marker or the channel-B marker. The preamble is followed by the sample, a validity flag, a user bit, a channel-status bit and a parity bit. The slots go out as biphase-mark coded half-slots, one half-slot per clock cycle, so a frame lasts 128 cycles.

Frames are counted in blocks of 192. The first frame of each block carries the block-start marker. Frame k of a block carries bit k of a 192-bit channel-status word for each channel, and both words are captured from input pins at the start of that block. Samples arrive on a valid/ready port that holds one pair in a single buffer slot. `s_ready` is high exactly when that slot is empty. A pair is taken on a rising edge where `s_valid` and `s_ready` are both high. While `s_valid` is high and `s_ready` is low, the source keeps the pair stable. If no pair is waiting at a frame boundary, transmission pauses and the line holds its level until a pair arrives.

Top module: `bmtx_top`

## Requirements
- R1: After reset `s_ready` is 1 and `line_out` is 0, and `line_out` stays 0 until the first pair is accepted.
- R2: The first half-slot of the first frame appears on `line_out` 2 clock edges after the accepting edge, and it is high.
- R3: In each frame, the first 64 half-slots carry channel A (`s_left`) and the next 64 carry channel B (`s_right`).
- R4: Slots 0-3 carry a preamble of 8 half-slots, sent first-half first. When the line was low at the end of the previous sub-frame the patterns are: block start 11101000, channel A 11100010, channel B 11100100. When the line was high they are inverted. Channel A uses the block-start pattern in frame 0 of each 192-frame block and the channel-A pattern otherwise. Channel B always uses the channel-B pattern.
- R5: Slots 4-27 carry the 24-bit sample, bit 0 in slot 4 and bit 23 in slot 27.
- R6: Slot 28 carries `s_unreliable` in both sub-frames of the frame (1 = unreliable).
- R7: Slot 29 is always 0.
- R8: Slot 30 of frame k of a block carries bit k of the channel-status word for that channel. The words come from `cs_word_a` and `cs_word_b`, captured when the first frame of the block loads. Changes to those inputs during a block have no effect until the next block.
- R9: Slot 31 makes the number of ones in slots 4-31 even.
- R10: Each data slot is biphase-mark coded. The line toggles at the start of every slot from 4 to 31, and toggles again mid-slot when the bit is 1.
- R11: The input holds one pair. `s_ready` falls the cycle after an acceptance. If no pair is buffered at a frame boundary, the line holds its level and the block counter resumes with the next frame.
- R12: With pairs always available, frames are contiguous at 128 cycles each, and one pair is accepted every 128 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-slot clock (128 cycles per frame) |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Buffer slot empty; pair taken when high with s_valid |
| s_left | input | 24 | Channel A sample, two's complement |
| s_right | input | 24 | Channel B sample, two's complement |
| s_unreliable | input | 1 | Validity flag for the pair, 1 = unreliable |
| cs_word_a | input | 192 | Channel-status word for channel A, bit k to frame k |
| cs_word_b | input | 192 | Channel-status word for channel B, bit k to frame k |
| line_out | output | 1 | Biphase-mark coded serial line |

## Verification
If a pair is taken on edge A while the serializer is idle, it loads on edge A+1, and its first half-slot is registered onto `line_out` on edge A+2. Each following half-slot then comes one cycle later. The bench records the negedge before each accepting edge and starts collecting half-slots at the third negedge after it. From there it takes exactly 64 samples per sub-frame, always at negedges, and decodes each sub-frame from those fixed windows. When a pair is ready in the buffer, the next frame continues without a gap, which is why a single alignment point holds for 400 frames. Acceptance spacing and buffer-full timing are checked at the negedge after the accepting edge.

// File: rtl/bmtx_pkg.sv
package bmtx_pkg;
  localparam int SLOTS      = 32;
  localparam int SUB_HALVES = 2 * SLOTS;
  localparam int SAMPLE_W   = 24;
  localparam int FIRST_DATA = 4;
  localparam int V_SLOT     = 28;
  localparam int U_SLOT     = 29;
  localparam int C_SLOT     = 30;
  localparam int P_SLOT     = 31;

  typedef enum logic [1:0] {
    SYNC_BLOCK = 2'd0,
    SYNC_CHA   = 2'd1,
    SYNC_CHB   = 2'd2
  } sync_e;

  // Eight half-slot levels for a preamble following a low line, first half at bit 7.
  function automatic logic [7:0] sync_levels(sync_e kind);
    case (kind)
      SYNC_BLOCK: return 8'b1110_1000;
      SYNC_CHA:   return 8'b1110_0010;
      SYNC_CHB:   return 8'b1110_0100;
      default:    return 8'b1110_0010;
    endcase
  endfunction
endpackage

// File: rtl/bmtx_sequencer.sv
module bmtx_sequencer
  import bmtx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int FCW          = $clog2(BLOCK_FRAMES),
  parameter int PW           = $clog2(2 * SUB_HALVES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SAMPLE_W-1:0]     in_a,
  input  logic [SAMPLE_W-1:0]     in_b,
  input  logic                    in_unrel,
  input  logic [BLOCK_FRAMES-1:0] in_cs_a,
  input  logic [BLOCK_FRAMES-1:0] in_cs_b,
  output logic                    run,
  output logic [PW-1:0]           pos,
  output logic [FCW-1:0]          fcnt,
  output logic [SAMPLE_W-1:0]     cur_a,
  output logic [SAMPLE_W-1:0]     cur_b,
  output logic                    cur_unrel,
  output logic [BLOCK_FRAMES-1:0] cs_a_q,
  output logic [BLOCK_FRAMES-1:0] cs_b_q
);
  localparam logic [PW-1:0]  LAST_POS   = PW'(2 * SUB_HALVES - 1);
  localparam logic [FCW-1:0] LAST_FRAME = FCW'(BLOCK_FRAMES - 1);

  logic                hold_full;
  logic [SAMPLE_W-1:0] hold_a, hold_b;
  logic                hold_unrel;
  logic                started;
  logic                at_boundary, load, take;

  assign in_ready    = !hold_full;
  assign take        = in_valid && !hold_full;
  assign at_boundary = !run || (pos == LAST_POS);
  assign load        = at_boundary && hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full  <= 1'b0;
      hold_a     <= '0;
      hold_b     <= '0;
      hold_unrel <= 1'b0;
    end else if (take) begin
      hold_full  <= 1'b1;
      hold_a     <= in_a;
      hold_b     <= in_b;
      hold_unrel <= in_unrel;
    end else if (load) begin
      hold_full  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      pos       <= '0;
      fcnt      <= '0;
      started   <= 1'b0;
      cur_a     <= '0;
      cur_b     <= '0;
      cur_unrel <= 1'b0;
      cs_a_q    <= '0;
      cs_b_q    <= '0;
    end else if (load) begin
      run       <= 1'b1;
      pos       <= '0;
      started   <= 1'b1;
      cur_a     <= hold_a;
      cur_b     <= hold_b;
      cur_unrel <= hold_unrel;
      if (started) fcnt <= (fcnt == LAST_FRAME) ? '0 : fcnt + 1'b1;
      if (!started || fcnt == LAST_FRAME) begin
        cs_a_q <= in_cs_a;
        cs_b_q <= in_cs_b;
      end
    end else if (run) begin
      if (pos == LAST_POS) run <= 1'b0;
      else                 pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/bmtx_slot_mux.sv
module bmtx_slot_mux
  import bmtx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int FCW          = $clog2(BLOCK_FRAMES)
) (
  input  logic                    chan_b,
  input  logic [4:0]              slot,
  input  logic [FCW-1:0]          fcnt,
  input  logic [SAMPLE_W-1:0]     smp_a,
  input  logic [SAMPLE_W-1:0]     smp_b,
  input  logic                    unrel,
  input  logic [BLOCK_FRAMES-1:0] cs_a,
  input  logic [BLOCK_FRAMES-1:0] cs_b,
  output logic                    bit_o,
  output logic                    in_sync,
  output sync_e                   sync_kind
);
  logic [SLOTS-1:0] word;

  always_comb begin
    word                          = '0;
    word[FIRST_DATA +: SAMPLE_W]  = chan_b ? smp_b : smp_a;
    word[V_SLOT]                  = unrel;
    word[U_SLOT]                  = 1'b0;
    word[C_SLOT]                  = chan_b ? cs_b[fcnt] : cs_a[fcnt];
    word[P_SLOT]                  = ^word[C_SLOT:FIRST_DATA];
  end

  assign bit_o   = word[slot];
  assign in_sync = (slot < 5'(FIRST_DATA));

  always_comb begin
    if (chan_b)          sync_kind = SYNC_CHB;
    else if (fcnt == '0) sync_kind = SYNC_BLOCK;
    else                 sync_kind = SYNC_CHA;
  end
endmodule

// File: rtl/bmtx_line_coder.sv
module bmtx_line_coder
  import bmtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       in_sync,
  input  logic [2:0] sync_idx,
  input  logic       sf_start,
  input  logic       second_half,
  input  logic       bit_i,
  input  sync_e      sync_kind,
  output logic       line_o
);
  logic       line_q, pol_q, pol, nxt;
  logic [7:0] pattern;

  assign pattern = sync_levels(sync_kind);
  assign pol     = sf_start ? line_q : pol_q;

  always_comb begin
    if (in_sync)           nxt = pattern[3'd7 - sync_idx] ^ pol;
    else if (!second_half) nxt = !line_q;
    else                   nxt = bit_i ? !line_q : line_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (run) begin
      line_q <= nxt;
      if (sf_start) pol_q <= line_q;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/bmtx_top.sv
module bmtx_top
  import bmtx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [SAMPLE_W-1:0]     s_left,
  input  logic [SAMPLE_W-1:0]     s_right,
  input  logic                    s_unreliable,
  input  logic [BLOCK_FRAMES-1:0] cs_word_a,
  input  logic [BLOCK_FRAMES-1:0] cs_word_b,
  output logic                    line_out
);
  localparam int FCW = $clog2(BLOCK_FRAMES);
  localparam int HW  = $clog2(SUB_HALVES);
  localparam int PW  = HW + 1;

  logic                    run;
  logic [PW-1:0]           pos;
  logic [FCW-1:0]          fcnt;
  logic [SAMPLE_W-1:0]     cur_a, cur_b;
  logic                    cur_unrel;
  logic [BLOCK_FRAMES-1:0] cs_a_q, cs_b_q;
  logic                    slot_bit, in_sync;
  sync_e                   sync_kind;

  bmtx_sequencer #(.BLOCK_FRAMES(BLOCK_FRAMES), .FCW(FCW), .PW(PW)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_ready(s_ready),
    .in_a(s_left), .in_b(s_right), .in_unrel(s_unreliable),
    .in_cs_a(cs_word_a), .in_cs_b(cs_word_b),
    .run(run), .pos(pos), .fcnt(fcnt),
    .cur_a(cur_a), .cur_b(cur_b), .cur_unrel(cur_unrel),
    .cs_a_q(cs_a_q), .cs_b_q(cs_b_q)
  );

  bmtx_slot_mux #(.BLOCK_FRAMES(BLOCK_FRAMES), .FCW(FCW)) mux_i (
    .chan_b(pos[PW-1]), .slot(pos[HW-1:1]), .fcnt(fcnt),
    .smp_a(cur_a), .smp_b(cur_b), .unrel(cur_unrel),
    .cs_a(cs_a_q), .cs_b(cs_b_q),
    .bit_o(slot_bit), .in_sync(in_sync), .sync_kind(sync_kind)
  );

  bmtx_line_coder coder_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .in_sync(in_sync), .sync_idx(pos[2:0]),
    .sf_start(pos[HW-1:0] == '0), .second_half(pos[0]),
    .bit_i(slot_bit), .sync_kind(sync_kind),
    .line_o(line_out)
  );
endmodule

// File: rtl/bmtx_checker.sv
module bmtx_checker #(
  parameter int BLOCK_FRAMES = 192,
  parameter int FCW          = $clog2(BLOCK_FRAMES)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_valid,
  input logic           s_ready,
  input logic           line_out,
  input logic           run,
  input logic [2:0]     slot_hi,
  input logic           half_b,
  input logic [FCW-1:0] fcnt
);
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                   seen <= 1'b0;
    else if (s_valid && s_ready)  seen <= 1'b1;
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !line_out);

  p_full_after_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_hold_when_paused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(line_out));

  p_slot_edge_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_b && slot_hi != 3'd0) |=> (line_out != $past(line_out)));

  p_frame_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fcnt) < BLOCK_FRAMES);
endmodule

bind bmtx_top bmtx_checker #(.BLOCK_FRAMES(BLOCK_FRAMES)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .line_out(line_out), .run(run), .slot_hi(pos[5:3]), .half_b(pos[0]),
  .fcnt(fcnt)
);

// File: tb/bmtx_top_tb_top.sv
`timescale 1ns/1ps
module bmtx_top_tb_top;
  localparam int NF = 400;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [23:0]  s_left = '0, s_right = '0;
  logic         s_unreliable = 1'b0;
  logic [191:0] cs_word_a = '0, cs_word_b = '0;
  logic         line_out;

  int  cyc = 0;
  int  nchk = 0, nerr = 0;
  bit  done = 0;
  logic last_lvl = 1'b0;
  int  rec_q [NF+2];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bmtx_top dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .s_unreliable(s_unreliable),
    .cs_word_a(cs_word_a), .cs_word_b(cs_word_b), .line_out(line_out)
  );

  function automatic logic [23:0] smp(int i, bit chb);
    logic [31:0] x;
    case (i)
      1: return chb ? 24'h7FFFFF : 24'h800000;
      2: return chb ? 24'h000000 : 24'hFFFFFF;
      3: return chb ? 24'h000001 : 24'h555555;
      default: begin
        x = 32'(i) * 32'h9E3779B1;
        return x[28:5] ^ (chb ? 24'h5A3C96 : 24'h000000);
      end
    endcase
  endfunction

  function automatic bit unrel(int i);
    return (i % 5) == 3;
  endfunction

  function automatic logic [191:0] csw(int blk, bit chb);
    logic [191:0] w;
    for (int j = 0; j < 192; j++) w[j] = ((j * 7 + blk * 13 + int'(chb) * 5) % 11) < 5;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic drive_pair(input int i, output int rec, output int waits);
    s_valid      = 1'b1;
    s_left       = smp(i, 0);
    s_right      = smp(i, 1);
    s_unreliable = unrel(i);
    waits = 0;
    while (!s_ready) begin
      @(negedge clk);
      waits++;
    end
    rec = cyc;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic recv_sub(output logic [63:0] h);
    for (int j = 0; j < 64; j++) begin
      @(negedge clk);
      h[j] = line_out;
    end
  endtask

  task automatic check_sub(input int k, input bit chb, input logic [63:0] h);
    logic [7:0]  pat, got;
    logic [31:0] dec;
    logic        prev, cbit, par;
    bit          bp_ok;
    int          blk;
    blk = k / 192;
    if (chb)              pat = 8'b1110_0100;
    else if (k % 192 == 0) pat = 8'b1110_1000;
    else                  pat = 8'b1110_0010;
    pat = pat ^ {8{last_lvl}};
    for (int j = 0; j < 8; j++) got[7-j] = h[j];
    chk(got == pat, "R4", $sformatf("preamble frame %0d ch%0d", k, chb), 32'(got), 32'(pat));
    bp_ok = 1; prev = h[7]; dec = '0;
    for (int s = 4; s < 32; s++) begin
      if (h[2*s] == prev) bp_ok = 0;
      dec[s] = h[2*s] ^ h[2*s+1];
      prev   = h[2*s+1];
    end
    chk(bp_ok, "R10", $sformatf("slot boundary toggles frame %0d ch%0d", k, chb), 32'(bp_ok), 32'd1);
    chk(dec[27:4] == smp(k, chb), "R3 R5", $sformatf("sample frame %0d ch%0d", k, chb),
        32'(dec[27:4]), 32'(smp(k, chb)));
    chk(dec[28] == unrel(k), "R6", $sformatf("validity frame %0d ch%0d", k, chb),
        32'(dec[28]), 32'(unrel(k)));
    chk(dec[29] == 1'b0, "R7", $sformatf("user bit frame %0d ch%0d", k, chb), 32'(dec[29]), 32'd0);
    cbit = csw(blk, chb)[k % 192];
    chk(dec[30] == cbit, "R8", $sformatf("status bit frame %0d ch%0d", k, chb), 32'(dec[30]), 32'(cbit));
    par = ^{smp(k, chb), unrel(k), cbit};
    chk(dec[31] == par, "R9", $sformatf("parity frame %0d ch%0d", k, chb), 32'(dec[31]), 32'(par));
    last_lvl = h[63];
  endtask

  task automatic recv_frame(input int k);
    logic [63:0] ha, hb;
    recv_sub(ha);
    recv_sub(hb);
    check_sub(k, 0, ha);
    check_sub(k, 1, hb);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R1", "ready after reset", 32'(s_ready), 32'd1);
    chk(line_out == 1'b0, "R1", "line after reset", 32'(line_out), 32'd0);
    repeat (20) begin
      @(negedge clk);
      chk(line_out == 1'b0, "R1", "line idle before first pair", 32'(line_out), 32'd0);
    end
  endtask

  task automatic t_stream;
    int w0, w;
    cs_word_a = csw(0, 0);
    cs_word_b = csw(0, 1);
    drive_pair(0, rec_q[0], w0);
    chk(s_ready == 1'b0, "R11", "ready low after take", 32'(s_ready), 32'd0);
    chk(line_out == 1'b0, "R2", "line low one edge after take", 32'(line_out), 32'd0);
    @(negedge clk);
    chk(line_out == 1'b0, "R2", "line low two edges before output", 32'(line_out), 32'd0);
    fork
      begin
        for (int i = 1; i < NF; i++) begin
          if (i == 100) begin cs_word_a = csw(1, 0); cs_word_b = csw(1, 1); end
          if (i == 300) begin cs_word_a = csw(2, 0); cs_word_b = csw(2, 1); end
          drive_pair(i, rec_q[i], w);
          if (i == 2) chk(w > 100, "R11", "source held off while buffer full", 32'(w), 32'd101);
          if (i >= 3 && (i % 50) == 0)
            chk(rec_q[i] - rec_q[i-1] == 128, "R12", "acceptance spacing",
                32'(rec_q[i] - rec_q[i-1]), 32'd128);
        end
      end
      begin
        for (int k = 0; k < NF; k++) begin
          if (k == 0) begin
            @(negedge clk);
            chk(line_out == 1'b1, "R2", "first half-slot high", 32'(line_out), 32'd1);
            last_lvl = 1'b0;
            recv_frame_first();
          end else begin
            recv_frame(k);
          end
        end
      end
    join
  endtask

  // First frame: the first half-slot was already sampled and checked above.
  task automatic recv_frame_first;
    logic [63:0] ha, hb;
    ha[0] = line_out;
    for (int j = 1; j < 64; j++) begin
      @(negedge clk);
      ha[j] = line_out;
    end
    recv_sub(hb);
    check_sub(0, 0, ha);
    check_sub(0, 1, hb);
  endtask

  task automatic t_starve;
    logic held;
    int   r, w;
    held = line_out;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (line_out != held || !s_ready)
        chk(0, "R11", "line held while starved", 32'(line_out), 32'(held));
    end
    chk(line_out == held, "R11", "line level after pause", 32'(line_out), 32'(held));
    chk(s_ready == 1'b1, "R11", "ready while starved", 32'(s_ready), 32'd1);
    drive_pair(NF, r, w);
    @(negedge clk);
    chk(line_out == held, "R11", "line held until resumed frame", 32'(line_out), 32'(held));
    fork
      begin
        drive_pair(NF + 1, r, w);
      end
      begin
        recv_frame(NF);
        recv_frame(NF + 1);
      end
    join
  endtask

  initial begin
    t_reset();
    t_stream();
    t_starve();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule